// File: doc/BRIEF.md
# Shared-Bus Register Operation Sequencer

This block performs one two-operand register operation at a time over a single shared 16-bit internal bus. It contains an eight-entry register file, an operand holding register, a single-adder ALU and a result holding register. The bus is the only data path between them, so the operands and the write-back have to cross it one after the other.

A command is given by a one-cycle start strobe together with an opcode, two source indices, a destination index and an immediate word. The block accepts the command only while idle. In the first busy cycle the first source goes over the bus into the operand register. In the second and third cycles the second source, or the immediate for the load-immediate opcode, is on the bus while the ALU works on it, and the result is captured at the end of the third. In the fourth cycle the result goes back over the bus into the destination register and the flags are committed. The bus value is brought out so that a user can observe each transfer.

Top module: `regop_sequencer`

## Requirements
- R1: After reset busy, done, carry and zero are 0, the bus reads 0 and every register holds 0.
- R2: In every cycle at most one of the three bus drivers (register file, immediate, result register) is enabled. With none enabled the bus reads 0.
- R3: A start seen on a clock edge while idle makes busy high for exactly four cycles. done is high only in the fourth of these cycles and lasts one cycle.
- R4: A start that arrives while busy is ignored, and the running sequence still ends after four cycles.
- R5: The bus carries the first source register in busy cycle 1, and the second source register in cycles 2 and 3. In cycle 4 it carries the result.
- R6: The opcode encodings are 0 add, 1 add with carry, 2 subtract (first minus second), 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 load immediate. Results are taken modulo 2^16.
- R7: For opcodes 0 and 1, carry is the carry out of bit 15. For opcodes 2 and 3, carry is 1 when a borrow is needed. Opcodes 1 and 3 take the current carry flag as the incoming carry or borrow. Opcodes 4 to 7 clear carry.
- R8: zero is 1 exactly when the written result is 0.
- R9: carry and zero change only on the clock edge that ends the write-back cycle.
- R10: When a source index equals the destination index, or both sources are equal, the result is the same as with distinct registers.
- R11: Load immediate (opcode 7) puts the immediate word on the bus in cycles 2 and 3 instead of the second source, and writes it to the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken only while idle |
| op | input | 3 | Opcode (see R6) |
| src_a | input | 3 | First source register index |
| src_b | input | 3 | Second source register index |
| dst | input | 3 | Destination register index |
| imm | input | 16 | Immediate word for load immediate |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | High during the write-back cycle |
| carry | output | 1 | Carry / borrow flag |
| zero | output | 1 | Result-is-zero flag |
| bus_mon | output | 16 | Current value of the shared bus |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that command fields only need to be valid on the edge where start is taken. They also assume that start may be high at any time, including all through a sequence. The stimulus applies reset for several cycles and changes inputs only on falling edges. In some runs it holds start high all through the busy window, so that the ignore rule is exercised without any timing ambiguity. The sweep covers every opcode with every pair of source indices, with destinations that rotate over all registers, so equal source and destination indices occur naturally.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  localparam int DATA_W = 16;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int NDRV   = 3;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_LDI = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LDOP = 3'd1,
    ST_COMP = 3'd2,
    ST_CAPT = 3'd3,
    ST_WB   = 3'd4
  } seq_st_e;

  // bus driver positions in the one-hot enable vector
  localparam int DRV_REG = 0;
  localparam int DRV_IMM = 1;
  localparam int DRV_OUT = 2;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              cout;
  } alu_out_t;

  // one shared adder; subtraction uses the inverted operand and carry-in
  function automatic alu_out_t alu_eval(op_e op, logic [DATA_W-1:0] a,
                                        logic [DATA_W-1:0] b, logic cin);
    alu_out_t          o;
    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   sum;
    b_eff = b;
    c_eff = 1'b0;
    case (op)
      OP_ADC: c_eff = cin;
      OP_SUB: begin b_eff = ~b; c_eff = 1'b1; end
      OP_SBB: begin b_eff = ~b; c_eff = ~cin; end
      default: ;
    endcase
    sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    o.cout = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin o.res = sum[DATA_W-1:0]; o.cout = sum[DATA_W]; end
      OP_SUB, OP_SBB: begin o.res = sum[DATA_W-1:0]; o.cout = ~sum[DATA_W]; end
      OP_AND: o.res = a & b;
      OP_OR:  o.res = a | b;
      OP_XOR: o.res = a ^ b;
      default: o.res = b;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/opseq_regfile.sv
module opseq_regfile
  import opseq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NREG,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);

  logic [N-1:0][W-1:0] regs_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g)) regs_q[g] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/opseq_bus.sv
module opseq_bus
  import opseq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NDRV
) (
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);

  logic [N:0][W-1:0] acc;
  assign acc[0] = '0;

  // AND-OR mux stands in for a tri-state bus
  for (genvar g = 0; g < N; g++) begin : g_drv
    assign acc[g+1] = acc[g] | (src[g] & {W{en[g]}});
  end

  assign bus = acc[N];

endmodule

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_ldi,
  output seq_st_e         st,
  output logic            accept,
  output logic            busy,
  output logic            done,
  output logic            rd_sel_b,
  output logic            opnd_we,
  output logic            out_we,
  output logic            wb_we,
  output logic [NDRV-1:0] drv
);

  seq_st_e st_q, st_d;

  assign accept = start && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_LDOP;
      ST_LDOP: st_d = ST_COMP;
      ST_COMP: st_d = ST_CAPT;
      ST_CAPT: st_d = ST_WB;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    drv = '0;
    case (st_q)
      ST_LDOP:          drv[DRV_REG] = 1'b1;
      ST_COMP, ST_CAPT: begin
        if (is_ldi) drv[DRV_IMM] = 1'b1;
        else        drv[DRV_REG] = 1'b1;
      end
      ST_WB:            drv[DRV_OUT] = 1'b1;
      default: ;
    endcase
  end

  assign st       = st_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_WB);
  assign rd_sel_b = (st_q == ST_COMP) || (st_q == ST_CAPT);
  assign opnd_we  = (st_q == ST_LDOP);
  assign out_we   = (st_q == ST_CAPT);
  assign wb_we    = (st_q == ST_WB);

  assert_step_ldop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_LDOP |=> st_q == ST_COMP);
  assert_step_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_COMP |=> st_q == ST_CAPT);
  assert_step_capt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_CAPT |=> st_q == ST_WB);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_wb_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/regop_sequencer.sv
module regop_sequencer
  import opseq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NREG,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] dst,
  input  logic [W-1:0]  imm,
  output logic          busy,
  output logic          done,
  output logic          carry,
  output logic          zero,
  output logic [W-1:0]  bus_mon
);

  seq_st_e            st;
  logic               accept, rd_sel_b, opnd_we, out_we, wb_we;
  logic [NDRV-1:0]    drv;
  logic [NDRV-1:0][W-1:0] drv_src;
  logic [W-1:0]       bus, rd_data;

  // latched command
  op_e           cmd_op_q;
  logic [IW-1:0] cmd_a_q, cmd_b_q, cmd_d_q;
  logic [W-1:0]  cmd_imm_q;

  // datapath holding registers and flags
  logic [W-1:0]  opnd_q, out_q;
  logic          cpend_q, carry_q, zero_q;
  alu_out_t      alu_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op_q  <= OP_ADD;
      cmd_a_q   <= '0;
      cmd_b_q   <= '0;
      cmd_d_q   <= '0;
      cmd_imm_q <= '0;
    end else if (accept) begin
      cmd_op_q  <= op_e'(op);
      cmd_a_q   <= src_a;
      cmd_b_q   <= src_b;
      cmd_d_q   <= dst;
      cmd_imm_q <= imm;
    end
  end

  opseq_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_ldi   (cmd_op_q == OP_LDI),
    .st       (st),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .rd_sel_b (rd_sel_b),
    .opnd_we  (opnd_we),
    .out_we   (out_we),
    .wb_we    (wb_we),
    .drv      (drv)
  );

  opseq_regfile #(.W(W), .N(N)) i_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_sel_b ? cmd_b_q : cmd_a_q),
    .rd_data (rd_data),
    .wr_en   (wb_we),
    .wr_idx  (cmd_d_q),
    .wr_data (bus)
  );

  assign drv_src[DRV_REG] = rd_data;
  assign drv_src[DRV_IMM] = cmd_imm_q;
  assign drv_src[DRV_OUT] = out_q;

  opseq_bus #(.W(W), .N(NDRV)) i_bus (
    .en  (drv),
    .src (drv_src),
    .bus (bus)
  );

  // ALU sees the held operand and whatever is on the bus
  assign alu_o = alu_eval(cmd_op_q, opnd_q, bus, carry_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q  <= '0;
      out_q   <= '0;
      cpend_q <= 1'b0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (opnd_we) opnd_q <= bus;
      if (out_we) begin
        out_q   <= alu_o.res;
        cpend_q <= alu_o.cout;
      end
      if (wb_we) begin
        carry_q <= cpend_q;
        zero_q  <= (bus == '0);
      end
    end
  end

  assign carry   = carry_q;
  assign zero    = zero_q;
  assign bus_mon = bus;

  assert_one_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv));
  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus == '0);
  assert_opnd_from_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_LDOP |=> opnd_q == $past(bus));
  assert_bus_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_COMP |=> $stable(bus));
  assert_wb_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_CAPT |=> bus == out_q);
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable({carry, zero}));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> zero == ($past(bus) == '0));

endmodule

// File: tb/test_regop_sequencer.sv
module test_regop_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [2:0]  src_a = '0, src_b = '0, dst = '0;
  logic [15:0] imm = '0;
  logic        busy, done, carry, zero;
  logic [15:0] bus_mon;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] mdl_reg [8];
  logic        mdl_c;
  logic        mdl_z;

  always #2 clk = ~clk;

  regop_sequencer i_regop_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_a(src_a),
    .src_b(src_b), .dst(dst), .imm(imm), .busy(busy), .done(done),
    .carry(carry), .zero(zero), .bus_mon(bus_mon)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected result and carry, written as plain integer arithmetic
  task automatic model(input int o, input int a, input int b, input int ci,
                       input int iv, output logic [15:0] r, output logic c);
    int t;
    c = 1'b0;
    case (o)
      0: begin t = a + b;      r = t[15:0]; c = (t > 65535); end
      1: begin t = a + b + ci; r = t[15:0]; c = (t > 65535); end
      2: begin t = a - b;      r = t[15:0]; c = (t < 0); end
      3: begin t = a - b - ci; r = t[15:0]; c = (t < 0); end
      4: r = 16'(a & b);
      5: r = 16'(a | b);
      6: r = 16'(a ^ b);
      default: r = 16'(iv);
    endcase
  endtask

  task automatic run_op(input int o, input int a, input int b, input int d,
                        input logic [15:0] iv, input bit hold_start);
    logic [15:0] r, vb;
    logic        c;
    model(o, mdl_reg[a], mdl_reg[b], mdl_c, iv, r, c);
    vb = (o == 7) ? iv : mdl_reg[b];
    @(negedge clk);
    start = 1'b1; op = 3'(o); src_a = 3'(a); src_b = 3'(b); dst = 3'(d); imm = iv;
    @(negedge clk);                           // busy cycle 1
    start = hold_start;
    op = ~op; src_a = ~src_a; imm = ~imm;     // fields after acceptance must not matter
    chk("R3 busy c1", busy, 1); chk("R3 done c1", done, 0);
    chk("R5 bus srcA", bus_mon, mdl_reg[a]);
    @(negedge clk);                           // cycle 2
    chk("R4 busy c2", busy, 1);
    chk((o == 7) ? "R11 bus imm c2" : "R5 bus srcB c2", bus_mon, vb);
    @(negedge clk);                           // cycle 3
    chk((o == 7) ? "R11 bus imm c3" : "R5 bus srcB c3", bus_mon, vb);
    chk("R9 flags held", {carry, zero}, {mdl_c, mdl_z});
    @(negedge clk);                           // cycle 4
    start = 1'b0;
    chk("R3 done c4", done, 1);
    chk((a == d || b == d) ? "R10 result same-index" : "R6 result", bus_mon, r);
    chk("R9 flags before wb", {carry, zero}, {mdl_c, mdl_z});
    @(negedge clk);                           // idle again
    chk("R3 busy end", busy, 0); chk("R3 done end", done, 0);
    chk("R2 idle bus", bus_mon, 0);
    mdl_reg[d] = r; mdl_c = c; mdl_z = (r == 16'h0);
    chk("R7 carry", carry, mdl_c);
    chk("R8 zero", zero, mdl_z);
  endtask

  initial begin
    logic [15:0] seeds [8];
    seeds[0] = 16'hFFFF; seeds[1] = 16'h0001; seeds[2] = 16'h8000; seeds[3] = 16'h0000;
    seeds[4] = 16'h7FFF; seeds[5] = 16'h1234; seeds[6] = 16'hA5A5; seeds[7] = 16'h00FF;
    for (int i = 0; i < 8; i++) mdl_reg[i] = '0;
    mdl_c = 1'b0; mdl_z = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 carry", carry, 0); chk("R1 zero", zero, 0);
    chk("R1 bus", bus_mon, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", busy, 0);
    // registers read back as zero after reset (OR of a register with itself)
    for (int i = 0; i < 8; i++) begin
      chk("R1 reg zero", mdl_reg[i], 0);
      run_op(5, i, i, i, 16'h0, 1'b0);
    end
    // sweep: reload seeds, then every opcode over every source pair
    for (int o = 0; o < 7; o++) begin
      for (int i = 0; i < 8; i++) run_op(7, i, (i + 3) % 8, i, seeds[(i + o) % 8], 1'b0);
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          run_op(o, a, b, (a + b + o) % 8, 16'h0, (a + b) % 2 == 1);
    end
    // carry chains through ADC / SBB
    run_op(7, 0, 0, 0, 16'hFFFF, 1'b0);
    run_op(7, 1, 1, 1, 16'h0001, 1'b0);
    run_op(0, 0, 1, 2, 16'h0, 1'b0);
    run_op(1, 1, 1, 3, 16'h0, 1'b1);
    run_op(2, 2, 1, 4, 16'h0, 1'b0);
    run_op(3, 4, 4, 5, 16'h0, 1'b0);
    run_op(3, 5, 5, 5, 16'h0, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule